// File: doc/BRIEF.md
# Buck Switching-Cycle Sequencer

This block turns the comparator decisions of a fixed-frequency, current-mode step-down regulator into gate commands. A cycle-start pulse marks the beginning of each switching period. It comes from the internal oscillator or from an external sync source, so the period can be anything from roughly 0.45 µs to 3.3 µs. The block drives the high-side gate, the low-side gate and a switch-node tri-state control. All comparator results arrive already synchronised to the system clock.

Within each cycle the sequencer turns the low side off, waits one dead clock, and then turns the high side on. The high side stays on until the PWM comparator trips or the peak-current flag ends the pulse, but never for less than a minimum on-time. Several rules override this normal flow:

- Every sixteenth cycle delays the high-side turn-on so that the bootstrap capacitor can recharge.
- A current limit seen while the feedback-low flag is set skips the next few cycles.
- Output overvoltage is looked at only when a cycle starts.
- Disable, supply loss and over-temperature tri-state the switch node right away.

A one-clock restart pulse tells the soft-start ramp, which is outside this block, to begin again.

Top module: `buck_cycle_seq`

## Requirements
- R1: At any clock edge where en_i is low, supply_ok_i is low or hot_i is high, both gates go low and sw_hiz_o goes high from that edge on. This overrides the minimum on-time. The same state holds during reset.
- R2: hs_gate_o and ls_gate_o are never high together. Every rise of either gate is preceded by at least one clock in which both are low.
- R3: Take a cycle start sampled at edge E while the low side is on, with no refresh and no skip pending. The low side stays on up to E, both gates are low from E+1, and the high side is on from E+2 until its on-time ends. After that there is one clock with both gates low, then the low side turns on.
- R4: Once the high side is on, it stays on for at least MIN_ON clocks (default 10, which is 100 ns at 100 MHz). Only a fault or a new cycle start can cut this short. A PWM trip seen earlier is ignored. With the trip held high, the high side falls at the edge where it has been on for MIN_ON clocks, or at the first trip edge after that.
- R5: Suppose ilim_i is sampled high at any edge while the high side is on. Then the pulse ends at the first edge where the minimum on-time is met, even if ilim_i has dropped again by then. This also holds for the first cycle after a restart.
- R6: Suppose a pulse ends with current limit as its cause and fb_low_i is high at that ending edge. Then the next SKIP_CYCLES (default 4) cycle starts give no high-side pulse, and the cycle start after them is handled normally.
- R7: Cycle starts are numbered 0 to 15 (REFRESH_EVERY-1), counting from the first start after tri-state and including skipped starts. On number 15 the high side is off at E and turns on at E+REFRESH_OFF+2 if the low side was on at E. If the high side was on at E, it turns on at E+REFRESH_OFF+3. The default REFRESH_OFF is 24 clocks, or 240 ns.
- R8: ovp_i has an effect only at a cycle-start edge. If it is high there, the switch node is tri-stated from that edge and no pulse follows. If it is high at any other edge, it is ignored. The block leaves tri-state at the first cycle start where ovp_i is low: the low side is on from that edge, the high side from E+2, and that start is numbered 0.
- R9: ss_restart_o is high for exactly one clock, starting at the first edge where en_i and supply_ok_i are high and hot_i is low after reset or after any edge where that was not so. The switch node stays tri-stated until the next cycle start.
- R10: With no trip and no current limit, the high side stays on across cycle starts that are not number 15. There is no dead clock at those starts, and the minimum on-time restarts. A number-15 start ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| supply_ok_i | input | 1 | Input supply above lockout threshold |
| hot_i | input | 1 | Over-temperature flag |
| cycle_start_i | input | 1 | One-clock pulse at each switching-period start |
| pwm_trip_i | input | 1 | PWM comparator: sensed current reached the control level |
| ilim_i | input | 1 | Peak-current limit flag |
| fb_low_i | input | 1 | Feedback far below target (hard short) |
| ovp_i | input | 1 | Output overvoltage flag |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| sw_hiz_o | output | 1 | Switch-node tri-state command |
| ss_restart_o | output | 1 | One-clock pulse asking the soft-start ramp to restart |

## Verification
Every output is decoded from a register, so an input sampled at edge E takes effect from E itself:

- a fault or an overvoltage start tri-states the node at E;
- the restart pulse covers E to E+1;
- a normal high-side pulse rises at E+2;
- the refresh delay adds REFRESH_OFF clocks, plus one more when the high side was still on.

The bench drives inputs on falling edges and samples on falling edges. For each cycle it pushes the expected rise time and width of the high-side pulse into a queue, computed from these latencies. A monitor measures every pulse in clock counts and compares it against that queue. Level checks are made at the falling edge just after the edge that should have changed the output.

// File: rtl/buck_cycle_seq.sv
module buck_cycle_seq #(
  parameter int MIN_ON        = 10,
  parameter int REFRESH_OFF   = 24,
  parameter int REFRESH_EVERY = 16,
  parameter int SKIP_CYCLES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic hot_i,
  input  logic cycle_start_i,
  input  logic pwm_trip_i,
  input  logic ilim_i,
  input  logic fb_low_i,
  input  logic ovp_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic sw_hiz_o,
  output logic ss_restart_o
);
  localparam int ONW  = (MIN_ON > 2) ? $clog2(MIN_ON) : 1;
  localparam int OFFW = $clog2(REFRESH_OFF + 1);
  localparam int CYW  = (REFRESH_EVERY > 2) ? $clog2(REFRESH_EVERY) : 1;
  localparam int SKW  = $clog2(SKIP_CYCLES + 1);

  typedef enum logic [2:0] {S_HIZ, S_LS, S_DL, S_DH, S_ON} phase_t;

  phase_t          st;
  logic            arm, ilim_hit, flt_q, ss_q;
  logic [ONW-1:0]  on_cnt;
  logic [OFFW-1:0] off_cnt;
  logic [CYW-1:0]  cyc_cnt;
  logic [SKW-1:0]  skip_cnt;

  logic fault_now, refresh_now, skip_now, min_done, end_on, cut_by_limit;
  assign fault_now    = !en_i || !supply_ok_i || hot_i;
  assign refresh_now  = cyc_cnt == CYW'(REFRESH_EVERY - 1);
  assign skip_now     = skip_cnt != '0;
  assign min_done     = on_cnt >= ONW'(MIN_ON - 1);
  assign cut_by_limit = ilim_i || ilim_hit;
  assign end_on       = min_done && (pwm_trip_i || cut_by_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HIZ;
      arm      <= 1'b0;
      ilim_hit <= 1'b0;
      on_cnt   <= '0;
      off_cnt  <= '0;
      cyc_cnt  <= '0;
      skip_cnt <= '0;
      flt_q    <= 1'b1;
      ss_q     <= 1'b0;
    end else begin
      flt_q <= fault_now;
      ss_q  <= flt_q && !fault_now;
      if (fault_now) begin
        st       <= S_HIZ;
        arm      <= 1'b0;
        ilim_hit <= 1'b0;
        on_cnt   <= '0;
        off_cnt  <= '0;
        cyc_cnt  <= '0;
        skip_cnt <= '0;
      end else if (cycle_start_i) begin
        if (ovp_i) begin
          st       <= S_HIZ;
          arm      <= 1'b0;
          off_cnt  <= '0;
          cyc_cnt  <= '0;
          skip_cnt <= '0;
        end else begin
          cyc_cnt <= refresh_now ? '0 : cyc_cnt + CYW'(1);
          arm     <= !skip_now;
          off_cnt <= (refresh_now && !skip_now) ? OFFW'(REFRESH_OFF) : '0;
          if (skip_now) skip_cnt <= skip_cnt - SKW'(1);
          case (st)
            S_HIZ: st <= S_LS;
            S_DL:  st <= S_LS;
            S_ON: begin
              if (skip_now || refresh_now) st <= S_DL;
              else begin
                on_cnt   <= '0;
                ilim_hit <= 1'b0;
              end
            end
            S_DH: begin
              if (skip_now || refresh_now) st <= S_LS;
              else begin
                st       <= S_ON;
                on_cnt   <= '0;
                ilim_hit <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end else begin
        case (st)
          S_LS: begin
            if (arm) begin
              if (off_cnt == '0) st <= S_DH;
              else off_cnt <= off_cnt - OFFW'(1);
            end
          end
          S_DL: st <= S_LS;
          S_DH: begin
            st       <= S_ON;
            on_cnt   <= '0;
            ilim_hit <= 1'b0;
          end
          S_ON: begin
            if (end_on) begin
              st  <= S_DL;
              arm <= 1'b0;
              if (cut_by_limit && fb_low_i) skip_cnt <= SKW'(SKIP_CYCLES);
            end else begin
              if (!min_done) on_cnt <= on_cnt + ONW'(1);
              if (ilim_i) ilim_hit <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign hs_gate_o    = st == S_ON;
  assign ls_gate_o    = st == S_LS;
  assign sw_hiz_o     = st == S_HIZ;
  assign ss_restart_o = ss_q;

  logic [ONW-1:0] hs_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_run <= '0;
    else if (!hs_gate_o) hs_run <= '0;
    else if (hs_run != ONW'(MIN_ON - 1)) hs_run <= hs_run + ONW'(1);
  end

  a_r1_fault_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (sw_hiz_o && !hs_gate_o && !ls_gate_o));

  a_r2_dead_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> !$past(ls_gate_o));

  a_r2_dead_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> !$past(hs_gate_o));

  a_r4_min_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate_o && !fault_now && !cycle_start_i && hs_run < ONW'(MIN_ON - 1)) |=> hs_gate_o);

  a_r8_ovp_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_start_i && !fault_now && !sw_hiz_o) |=> !sw_hiz_o);
endmodule

// File: tb/sim_buck_cycle_seq.sv
module sim_buck_cycle_seq;
  localparam int MIN_ON = 10;
  localparam int P      = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, sok = 1'b0, hot = 1'b0, cs = 1'b0, trip = 1'b0;
  logic ilim = 1'b0, fbl = 1'b0, ovp = 1'b0;
  logic hs, ls, hiz, ss;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int q_rise[$], q_w[$];
  string q_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  buck_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sok), .hot_i(hot),
    .cycle_start_i(cs), .pwm_trip_i(trip), .ilim_i(ilim), .fb_low_i(fbl), .ovp_i(ovp),
    .hs_gate_o(hs), .ls_gate_o(ls), .sw_hiz_o(hiz), .ss_restart_o(ss)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (clock %0d)", req, what, act, exp, cyc);
    end
  endtask

  logic hs_p = 1'b0, ls_p = 1'b0;
  int rise_at = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs && ls) check(1'b0, "R2", "gates overlap", 1, 0);
      if (hs && !hs_p) begin
        rise_at = cyc;
        check(!ls_p, "R2", "low side high before high-side rise", int'(ls_p), 0);
      end
      if (ls && !ls_p) check(!hs_p, "R2", "high side high before low-side rise", int'(hs_p), 0);
      if (!hs && hs_p) begin
        if (q_rise.size() == 0) check(1'b0, "R6", "unexpected high-side pulse at", rise_at, -1);
        else begin
          automatic int er = q_rise.pop_front();
          automatic int ew = q_w.pop_front();
          automatic string et = q_tag.pop_front();
          check(rise_at == er, et, "pulse rise clock", rise_at, er);
          check(cyc - rise_at == ew, et, "pulse width", cyc - rise_at, ew);
        end
      end
    end
    hs_p <= hs;
    ls_p <= ls;
  end

  task automatic run_cycle(input int d, input int tt, input bit by_ilim, input bit fb,
                           input bit ovp0, input int ovp_t, input int hot_t,
                           input bit exp_hs, input int wo, input string tag);
    int s, e0, r, f, w;
    s  = cyc;
    e0 = s + 1;
    cs = 1'b1; ovp = ovp0; fbl = fb; trip = 1'b0; ilim = 1'b0;
    r = e0 + 2 + d;
    f = (e0 + tt > r + MIN_ON) ? e0 + tt : r + MIN_ON;
    w = (wo > 0) ? wo : f - r;
    if (exp_hs) begin
      q_rise.push_back(r);
      q_w.push_back(w);
      q_tag.push_back(tag);
    end
    for (int k = 1; k < P; k++) begin
      @(negedge clk);
      cs  = 1'b0;
      ovp = (ovp_t >= 0) && (cyc == e0 + ovp_t - 1);
      if (hot_t >= 0 && cyc >= e0 + hot_t - 1) hot = 1'b1;
      if (tt >= 0) begin
        if (by_ilim) ilim = (cyc == e0 + tt - 1);
        else trip = (cyc >= e0 + tt - 1);
      end
    end
    @(negedge clk);
    trip = 1'b0; ilim = 1'b0; ovp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hiz && !hs && !ls, "R1", "reset state tri-stated", int'(hiz), 1);
    check(!ss, "R9", "no restart pulse in reset", int'(ss), 0);
    rst_n = 1'b1; en = 1'b1; sok = 1'b1;
    @(negedge clk);
    check(ss, "R9", "restart pulse on release", int'(ss), 1);
    check(hiz, "R8", "tri-state kept until cycle start", int'(hiz), 1);
    @(negedge clk);
    check(!ss, "R9", "restart pulse one clock", int'(ss), 0);

    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R3");
    run_cycle(0, 5,  0, 0, 0, -1, -1, 1, 0, "R4");
    run_cycle(0, 20, 1, 0, 0, -1, -1, 1, 0, "R5");
    run_cycle(0, 4,  1, 0, 0, -1, -1, 1, 0, "R5");
    run_cycle(0, 25, 1, 1, 0, -1, -1, 1, 0, "R6");
    for (int i = 0; i < 4; i++) run_cycle(0, 30, 0, 0, 0, -1, -1, 0, 0, "R6");
    check(ls && !hiz, "R6", "low side on after skipped cycles", int'(ls), 1);
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R6");
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R3");
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R3");
    run_cycle(0, -1, 0, 0, 0, -1, -1, 1, P + 28, "R10");
    run_cycle(0, 30, 0, 0, 0, -1, -1, 0, 0, "R10");
    run_cycle(0, -1, 0, 0, 0, -1, -1, 1, P - 2, "R10");
    run_cycle(25, 40, 0, 0, 0, -1, -1, 1, 0, "R7");
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R7");

    run_cycle(0, 30, 0, 0, 0, 20, -1, 1, 0, "R8");
    check(!hiz, "R8", "mid-cycle overvoltage ignored", int'(hiz), 0);
    run_cycle(0, 30, 0, 0, 1, -1, -1, 0, 0, "R8");
    check(hiz && !ls && !hs, "R8", "overvoltage at start tri-states", int'(hiz), 1);
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R8");
    for (int i = 0; i < 14; i++) run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R7");
    run_cycle(24, 40, 0, 0, 0, -1, -1, 1, 0, "R7");

    run_cycle(0, 30, 0, 0, 0, -1, 20, 1, 18, "R9");
    check(hiz && !hs && !ls, "R9", "thermal fault tri-states", int'(hiz), 1);
    run_cycle(0, 30, 0, 0, 0, -1, -1, 0, 0, "R9");
    check(hiz, "R9", "start ignored while hot", int'(hiz), 1);
    hot = 1'b0;
    @(negedge clk);
    check(ss, "R9", "restart pulse after cooling", int'(ss), 1);
    check(hiz, "R9", "tri-state until next start", int'(hiz), 1);
    @(negedge clk);
    check(!ss, "R9", "restart pulse one clock", int'(ss), 0);
    run_cycle(0, 20, 1, 0, 0, -1, -1, 1, 0, "R5");

    en = 1'b0;
    @(negedge clk);
    check(hiz && !hs && !ls, "R1", "disable tri-states", int'(hiz), 1);
    en = 1'b1;
    @(negedge clk);
    check(ss, "R9", "restart pulse on enable", int'(ss), 1);
    sok = 1'b0;
    @(negedge clk);
    check(hiz && !hs && !ls, "R1", "supply loss tri-states", int'(hiz), 1);
    sok = 1'b1;
    @(negedge clk);
    check(ss, "R9", "restart pulse on supply return", int'(ss), 1);
    run_cycle(0, 30, 0, 0, 0, -1, -1, 1, 0, "R1");
    repeat (5) @(negedge clk);
    check(q_rise.size() == 0, "R3", "expected pulses outstanding", q_rise.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule